// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider

This block divides a fast input clock by a programmable integer and emits one single-cycle pulse per division period, meant for a phase comparator. In its dual-modulus modes, a prescaler counts either P+1 or P input cycles per step. A swallow counter A sets how many of those steps use the long modulus. A main counter B sets how many steps make up one output period. The total period is therefore P*B + A input cycles.

Three fixed-divide modes bypass the swallow scheme. In these modes the prescaler always counts a fixed value F of 1, 2 or 3, and the period is F*B.

The divide settings are sampled only at period boundaries or on a restart, so an output period never mixes two configurations. Restart comes from reset, from a synchronous counter-clear input or from a resync strobe. A swallow count larger than the main count is clamped and reported on an error output.

Top module: `fbdiv_top`

## Requirements
- R1: `mode_i` values 0 to 4 select dual-modulus operation with P = 2, 4, 8, 16 and 32 respectively. In these modes the interval between consecutive `pulse_o` rising edges is P*B + A input cycles.
- R2: In a dual-modulus period, the first A prescaler steps last P+1 cycles and the remaining B-A steps last P cycles. With A equal to B the period is therefore (P+1)*B.
- R3: `mode_i` values 5, 6 and 7 select fixed division by F = 1, 2 and 3. In these modes `a_i` is ignored, the period is F*B and `cfg_err_o` stays low.
- R4: If `a_i` exceeds the effective B in a dual-modulus mode, A is clamped to B (period P*B + B) and `cfg_err_o` is high while that configuration is active.
- R5: A programmed `b_i` of 0 acts as B = 1.
- R6: `pulse_o` is high for exactly one input cycle per period, except when the period is one cycle, in which case it stays high.
- R7: New `mode_i`, `a_i` and `b_i` values take effect only at the end of the running period. The period in progress completes with the old values.
- R8: A cycle with `cnt_clr_i` or `resync_i` high restarts the counters from the current inputs. No pulse appears in the following cycle, and the first pulse comes N cycles after the restart edge.
- R9: While `rst_n` is low, `pulse_o` and `cfg_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_clr_i | input | 1 | Synchronous counter clear and reload |
| resync_i | input | 1 | Synchronous resync strobe, same effect as clear |
| mode_i | input | 3 | Prescaler mode selector |
| a_i | input | AW (6) | Swallow count A |
| b_i | input | BW (13) | Main count B |
| pulse_o | output | 1 | One-cycle pulse at each period end |
| cfg_err_o | output | 1 | Active configuration had A greater than B |

## Verification
The assertions assume that `rst_n` is released synchronously to `clk`. They also assume that `mode_i`, `a_i` and `b_i` are settled whenever a restart or a period end can sample them. Under these assumptions the prescaler count stays within the active modulus and the swallow count never exceeds the main count. The stimulus changes settings only at the falling edge, one half cycle away from any sampling edge. It also holds each restart strobe for exactly one cycle, and it keeps B small enough that every measured period ends well before the run limit.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

    // width of the prescaler down counter (largest modulus minus one is 32)
    localparam int PCW = 6;

    typedef enum logic [2:0] {
        PS_DM2  = 3'd0,
        PS_DM4  = 3'd1,
        PS_DM8  = 3'd2,
        PS_DM16 = 3'd3,
        PS_DM32 = 3'd4,
        PS_FIX1 = 3'd5,
        PS_FIX2 = 3'd6,
        PS_FIX3 = 3'd7
    } ps_mode_e;

    // dual-modulus modes occupy the low five codes
    function automatic logic mode_is_dm(input logic [2:0] m);
        return (m <= 3'(PS_DM32));
    endfunction

    // base modulus: P for dual-modulus modes, F for fixed modes
    function automatic logic [PCW-1:0] mode_base(input logic [2:0] m);
        logic [PCW-1:0] r;
        case (ps_mode_e'(m))
            PS_DM2:  r = PCW'(2);
            PS_DM4:  r = PCW'(4);
            PS_DM8:  r = PCW'(8);
            PS_DM16: r = PCW'(16);
            PS_DM32: r = PCW'(32);
            PS_FIX1: r = PCW'(1);
            PS_FIX2: r = PCW'(2);
            default: r = PCW'(3);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fbdiv_cfg_sel.sv
module fbdiv_cfg_sel
    import fbdiv_pkg::*;
#(
    parameter int AW = 6,
    parameter int BW = 13
) (
    input  logic [2:0]     mode_i,
    input  logic [AW-1:0]  a_raw_i,
    input  logic [BW-1:0]  b_raw_i,
    output logic           dm_o,
    output logic [PCW-1:0] base_o,
    output logic [AW-1:0]  a_eff_o,
    output logic [BW-1:0]  b_eff_o,
    output logic           err_o
);

    logic [BW-1:0] a_ext;
    logic          a_over;

    always_comb begin
        dm_o    = mode_is_dm(mode_i);
        base_o  = mode_base(mode_i);
        b_eff_o = (b_raw_i == '0) ? BW'(1) : b_raw_i;
        a_ext   = BW'(a_raw_i);
        a_over  = (a_ext > b_eff_o);
        err_o   = dm_o && a_over;
        if (!dm_o) begin
            a_eff_o = '0;
        end else if (a_over) begin
            a_eff_o = AW'(b_eff_o);
        end else begin
            a_eff_o = a_raw_i;
        end
    end

endmodule

// File: rtl/fbdiv_prescaler.sv
module fbdiv_prescaler
    import fbdiv_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           restart_i,
    input  logic [PCW-1:0] next_m1_i,
    output logic [PCW-1:0] pc_o,
    output logic           tick_o
);

    typedef struct packed {
        logic [PCW-1:0] pc;
    } ps_state_t;

    ps_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tick_o = !restart_i && (st_q.pc == '0);
        if (restart_i || (st_q.pc == '0)) begin
            st_d.pc = next_m1_i;
        end else begin
            st_d.pc = st_q.pc - PCW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o = st_q.pc;

endmodule

// File: rtl/fbdiv_swallow.sv
module fbdiv_swallow
    import fbdiv_pkg::*;
#(
    parameter int AW = 6,
    parameter int BW = 13
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           restart_i,
    input  logic           tick_i,
    input  logic           new_dm_i,
    input  logic [PCW-1:0] new_base_i,
    input  logic [AW-1:0]  new_a_i,
    input  logic [BW-1:0]  new_b_i,
    input  logic           new_err_i,
    output logic           term_o,
    output logic [PCW-1:0] next_m1_o,
    output logic           pulse_o,
    output logic           err_o,
    output logic           act_dm_o,
    output logic [PCW-1:0] act_base_o,
    output logic [AW-1:0]  act_a_o,
    output logic [BW-1:0]  act_b_o,
    output logic [AW-1:0]  a_cnt_o,
    output logic [BW-1:0]  b_cnt_o
);

    typedef struct packed {
        logic           dm;
        logic [PCW-1:0] base;
        logic [AW-1:0]  a;
        logic [BW-1:0]  b;
        logic           err;
        logic [AW-1:0]  a_cnt;
        logic [BW-1:0]  b_cnt;
        logic           pulse;
    } sw_state_t;

    sw_state_t st_d, st_q;
    logic      last_step;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        last_step  = (st_q.b_cnt == BW'(1));
        term_o     = tick_i && last_step;

        if (restart_i || term_o) begin
            st_d.dm    = new_dm_i;
            st_d.base  = new_base_i;
            st_d.a     = new_a_i;
            st_d.b     = new_b_i;
            st_d.err   = new_err_i;
            st_d.a_cnt = new_a_i;
            st_d.b_cnt = new_b_i;
            st_d.pulse = term_o;
        end else if (tick_i) begin
            st_d.b_cnt = st_q.b_cnt - BW'(1);
            if (st_q.a_cnt != '0) begin
                st_d.a_cnt = st_q.a_cnt - AW'(1);
            end
        end

        // modulus minus one for the step that starts after this edge
        if (st_d.dm && (st_d.a_cnt != '0)) begin
            next_m1_o = st_d.base;
        end else begin
            next_m1_o = st_d.base - PCW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.dm    <= 1'b1;
            st_q.base  <= PCW'(2);
            st_q.a     <= '0;
            st_q.b     <= BW'(1);
            st_q.err   <= 1'b0;
            st_q.a_cnt <= '0;
            st_q.b_cnt <= BW'(1);
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o    = st_q.pulse;
    assign err_o      = st_q.err;
    assign act_dm_o   = st_q.dm;
    assign act_base_o = st_q.base;
    assign act_a_o    = st_q.a;
    assign act_b_o    = st_q.b;
    assign a_cnt_o    = st_q.a_cnt;
    assign b_cnt_o    = st_q.b_cnt;

endmodule

// File: rtl/fbdiv_top.sv
module fbdiv_top
    import fbdiv_pkg::*;
#(
    parameter int AW = 6,
    parameter int BW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_clr_i,
    input  logic          resync_i,
    input  logic [2:0]    mode_i,
    input  logic [AW-1:0] a_i,
    input  logic [BW-1:0] b_i,
    output logic          pulse_o,
    output logic          cfg_err_o
);

    typedef struct packed {
        logic boot;
    } top_state_t;

    top_state_t     st_d, st_q;
    logic           restart_w;
    logic           tick_w;
    logic           term_w;
    logic [PCW-1:0] pc_w;
    logic [PCW-1:0] next_m1_w;
    logic           new_dm_w;
    logic [PCW-1:0] new_base_w;
    logic [AW-1:0]  new_a_w;
    logic [BW-1:0]  new_b_w;
    logic           new_err_w;
    logic           act_dm_w;
    logic [PCW-1:0] act_base_w;
    logic [AW-1:0]  act_a_w;
    logic [BW-1:0]  act_b_w;
    logic [AW-1:0]  a_cnt_w;
    logic [BW-1:0]  b_cnt_w;

    // first cycle after reset loads the configuration like a restart
    always_comb begin
        st_d      = st_q;
        st_d.boot = 1'b0;
        restart_w = st_q.boot || cnt_clr_i || resync_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.boot <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    fbdiv_cfg_sel #(.AW(AW), .BW(BW)) u_cfg (
        .mode_i  (mode_i),
        .a_raw_i (a_i),
        .b_raw_i (b_i),
        .dm_o    (new_dm_w),
        .base_o  (new_base_w),
        .a_eff_o (new_a_w),
        .b_eff_o (new_b_w),
        .err_o   (new_err_w)
    );

    fbdiv_prescaler u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart_w),
        .next_m1_i (next_m1_w),
        .pc_o      (pc_w),
        .tick_o    (tick_w)
    );

    fbdiv_swallow #(.AW(AW), .BW(BW)) u_sw (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart_i  (restart_w),
        .tick_i     (tick_w),
        .new_dm_i   (new_dm_w),
        .new_base_i (new_base_w),
        .new_a_i    (new_a_w),
        .new_b_i    (new_b_w),
        .new_err_i  (new_err_w),
        .term_o     (term_w),
        .next_m1_o  (next_m1_w),
        .pulse_o    (pulse_o),
        .err_o      (cfg_err_o),
        .act_dm_o   (act_dm_w),
        .act_base_o (act_base_w),
        .act_a_o    (act_a_w),
        .act_b_o    (act_b_w),
        .a_cnt_o    (a_cnt_w),
        .b_cnt_o    (b_cnt_w)
    );

endmodule

// File: rtl/fbdiv_chk.sv
module fbdiv_chk
    import fbdiv_pkg::*;
#(
    parameter int AW = 6,
    parameter int BW = 13
) (
    input logic           clk,
    input logic           rst_n,
    input logic           restart,
    input logic           term,
    input logic           pulse,
    input logic           cfg_err,
    input logic [PCW-1:0] pc,
    input logic           act_dm,
    input logic [PCW-1:0] act_base,
    input logic [AW-1:0]  act_a,
    input logic [BW-1:0]  act_b,
    input logic [AW-1:0]  a_cnt,
    input logic [BW-1:0]  b_cnt
);

    AST_PC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        act_dm ? (pc <= act_base) : (pc < act_base)); // R2

    AST_SWALLOW_LE_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        BW'(a_cnt) <= b_cnt); // R2

    AST_A_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
        BW'(act_a) <= act_b); // R4

    AST_FIXED_NO_SWALLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !act_dm |-> (a_cnt == '0 && !cfg_err)); // R3

    AST_B_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        act_b != '0); // R5

    AST_PULSE_FROM_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> $past(term)); // R6

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(restart || term) |=> $stable({act_dm, act_base, act_a, act_b, cfg_err})); // R7

    AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !pulse); // R8

endmodule

bind fbdiv_top fbdiv_chk #(.AW(AW), .BW(BW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart_w),
    .term     (term_w),
    .pulse    (pulse_o),
    .cfg_err  (cfg_err_o),
    .pc       (pc_w),
    .act_dm   (act_dm_w),
    .act_base (act_base_w),
    .act_a    (act_a_w),
    .act_b    (act_b_w),
    .a_cnt    (a_cnt_w),
    .b_cnt    (b_cnt_w)
);

// File: tb/sim_fbdiv_top.sv
`timescale 1ns/1ps
module sim_fbdiv_top;

    localparam int AW    = 6;
    localparam int BW    = 13;
    localparam int LIMIT = 3000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cnt_clr_i = 1'b0;
    logic          resync_i = 1'b0;
    logic [2:0]    mode_i = 3'd0;
    logic [AW-1:0] a_i = '0;
    logic [BW-1:0] b_i = BW'(1);
    logic          pulse_o;
    logic          cfg_err_o;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;

    always #2 clk = ~clk;

    fbdiv_top #(.AW(AW), .BW(BW)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_clr_i (cnt_clr_i),
        .resync_i  (resync_i),
        .mode_i    (mode_i),
        .a_i       (a_i),
        .b_i       (b_i),
        .pulse_o   (pulse_o),
        .cfg_err_o (cfg_err_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    // negedges until pulse_o is seen high
    task automatic count_to_pulse(output int n);
        n = 0;
        for (int i = 0; i < LIMIT; i++) begin
            @(negedge clk);
            n++;
            if (pulse_o) break;
        end
    endtask

    task automatic restart_with(input logic [2:0] m, input int a, input int b, input bit use_clr);
        @(negedge clk);
        mode_i = m;
        a_i    = AW'(a);
        b_i    = BW'(b);
        if (use_clr) cnt_clr_i = 1'b1; else resync_i = 1'b1;
        @(negedge clk);
        cnt_clr_i = 1'b0;
        resync_i  = 1'b0;
    endtask

    task automatic measure(input string req, input int exp);
        int n;
        count_to_pulse(n);
        count_to_pulse(n);
        chk(req, n, exp);
        count_to_pulse(n);
        chk(req, n, exp);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 pulse in reset", int'(pulse_o), 0);
        chk("R9 err in reset", int'(cfg_err_o), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_dual_modulus();
        restart_with(3'd0, 1, 3, 1'b0);
        measure("R1 P2 A1 B3", 7);
        restart_with(3'd2, 5, 7, 1'b0);
        measure("R1 P8 A5 B7", 61);
        restart_with(3'd1, 0, 5, 1'b0);
        measure("R1 P4 A0 B5", 20);
        restart_with(3'd4, 31, 40, 1'b0);
        measure("R1 P32 A31 B40", 1311);
        chk("R1 no error", int'(cfg_err_o), 0);
    endtask

    task automatic t_full_swallow();
        restart_with(3'd3, 4, 4, 1'b0);
        measure("R2 P16 A=B=4", 68);
        restart_with(3'd0, 6, 6, 1'b0);
        measure("R2 P2 A=B=6", 18);
    endtask

    task automatic t_fixed();
        restart_with(3'd6, 7, 9, 1'b0);
        measure("R3 F2 B9", 18);
        restart_with(3'd7, 63, 5, 1'b0);
        measure("R3 F3 B5 A ignored", 15);
        chk("R3 no error in fixed mode", int'(cfg_err_o), 0);
    endtask

    task automatic t_clamp();
        restart_with(3'd4, 9, 2, 1'b0);
        measure("R4 P32 A9 clamps to B2", 66);
        chk("R4 error flag", int'(cfg_err_o), 1);
        restart_with(3'd1, 2, 3, 1'b0);
        @(negedge clk);
        chk("R4 error clears", int'(cfg_err_o), 0);
    endtask

    task automatic t_b_zero();
        restart_with(3'd1, 0, 0, 1'b0);
        measure("R5 P4 B0", 4);
        restart_with(3'd0, 3, 0, 1'b0);
        measure("R5 P2 B0 A clamp", 3);
    endtask

    task automatic t_pulse_width();
        int highs;
        restart_with(3'd5, 0, 1, 1'b0);
        @(negedge clk);
        highs = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (pulse_o) highs++;
        end
        chk("R6 period one stays high", highs, 8);
        restart_with(3'd0, 1, 2, 1'b0);
        highs = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (pulse_o) highs++;
        end
        chk("R6 one-cycle pulses per 5-cycle period", highs, 10);
    endtask

    task automatic t_take_effect();
        int n;
        restart_with(3'd0, 1, 3, 1'b0);
        count_to_pulse(n);
        repeat (2) @(negedge clk);
        mode_i = 3'd1;
        a_i    = AW'(2);
        b_i    = BW'(4);
        count_to_pulse(n);
        chk("R7 running period keeps old values", n, 5);
        count_to_pulse(n);
        chk("R7 next period uses new values", n, 18);
    endtask

    task automatic t_restart();
        int n;
        restart_with(3'd2, 2, 3, 1'b1);
        count_to_pulse(n);
        chk("R8 clear to first pulse", n, 26);
        restart_with(3'd0, 1, 3, 1'b0);
        count_to_pulse(n);
        chk("R8 resync to first pulse", n, 7);
    endtask

    initial begin
        t_reset();
        t_dual_modulus();
        t_full_swallow();
        t_fixed();
        t_clamp();
        t_b_zero();
        t_pulse_width();
        t_take_effect();
        t_restart();
        finish_run();
    end

endmodule